// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This unit sits next to a real-time clock counter and turns the counter's progress into interrupt events. The counter supplies the current time as six packed BCD fields and one strobe for each unit boundary it crosses: second, minute, hour and day. The unit keeps six BCD alarm fields and compares them with the live time on every seconds strobe. It latches each event in a sticky status register and raises one level-sensitive interrupt line for the sources that are enabled.

Software reaches the unit through a small synchronous register port with a combinational read path. Writing a one to a status bit clears that bit. The interrupt register holds the enable bits and a two-bit field that picks which periodic boundary drives the interrupt line. A power-up flag is set by reset, so software can tell a cold start from a warm one. Because the alarm enable is kept separately from the timer enable, software can leave only the alarm armed when the system goes down, and an alarm match then still raises the line.

Top module: `rtc_event_unit`

## Requirements
- R1: Alarm fields seconds, minutes, hours, day, month and year are 8-bit read/write registers at addresses 0x07, 0x08, 0x09, 0x0A, 0x0B and 0x0C in that order. All reset to 0x00.
- R2: The interrupt register at 0x0F resets to 0x00. Bits 1:0 are the period select, bit 2 is the periodic (timer) enable and bit 3 is the alarm enable. Bits 7:4 read as zero and ignore writes.
- R3: Status register 0x0E bit 2, 3, 4 or 5 is set one cycle after a high `tick_sec`, `tick_min`, `tick_hour` or `tick_day` respectively. This happens whatever the enables are.
- R4: Status bit 6 is set one cycle after a `tick_sec` on which all six fields of `now_time` equal the six alarm fields, provided they were not all equal at the previous `tick_sec`.
- R5: The alarm does not fire again on a `tick_sec` whose fields still equal the alarm, when the previous `tick_sec` also matched. Cycles without `tick_sec` never set bit 6.
- R6: Reset sets status bit 7 (power-up). The bit stays set until software clears it.
- R7: Writing a value to 0x0E clears every status bit whose written bit is one and leaves the others unchanged. Status bits 1:0 always read zero.
- R8: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` equals (status bit 6 AND alarm enable) OR (status bit 2+period select AND timer enable), where period select 00, 01, 10 and 11 picks second, minute, hour and day. The line stays high until the causing bit is cleared or its enable is dropped.
- R10: Reads of addresses other than 0x07 to 0x0C, 0x0E and 0x0F return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| now_time | input | 48 | Live BCD time: seconds in bits 7:0, then minutes, hours, day, month, year in bits 47:40 |
| tick_sec | input | 1 | One-cycle strobe when the seconds field advances |
| tick_min | input | 1 | One-cycle strobe at a minute boundary |
| tick_hour | input | 1 | One-cycle strobe at an hour boundary |
| tick_day | input | 1 | One-cycle strobe at a day boundary |
| irq | output | 1 | Shared interrupt request, active high |

## Verification
The case most likely to go wrong is an event strobe that lands in the same cycle as a software write-one-to-clear of the same status bit, since the event must not be lost. The bench forces this directly: it pulses `tick_min` while writing 0x08 to the status register, and pulses `tick_sec` while writing a fully matching alarm time together with a clear of bit 6. It then reads the status back and expects the bits set. A randomized phase also mixes status writes with strobes and alarm matches, and every cycle it compares `irq` and the read data with a behavioural model.

// File: rtl/rtc_event_unit.sv
module rtc_event_unit #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int NFLD     = 6,
  parameter int ALM_BASE = 7,
  parameter int STS_ADR  = 14,
  parameter int INT_ADR  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NFLD*DW-1:0] now_time,
  input  logic             tick_sec,
  input  logic             tick_min,
  input  logic             tick_hour,
  input  logic             tick_day,
  output logic             irq
);
  localparam logic [AW-1:0] STS_A = AW'(STS_ADR);
  localparam logic [AW-1:0] INT_A = AW'(INT_ADR);

  logic [DW-1:0]   alm [NFLD];
  logic [NFLD-1:0] fld_eq;
  logic            match, match_q, alarm_hit;
  logic [7:2]      sts, sts_set, sts_clr;
  logic [3:0]      ictl;
  logic [3:0]      per_sts;
  logic            sts_wr, int_wr;

  assign sts_wr = reg_we && (reg_addr == STS_A);
  assign int_wr = reg_we && (reg_addr == INT_A);

  for (genvar g = 0; g < NFLD; g++) begin : g_alm
    localparam logic [AW-1:0] FA = AW'(ALM_BASE + g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        alm[g] <= '0;
      else if (reg_we && reg_addr == FA) alm[g] <= reg_wdata;
    assign fld_eq[g] = (now_time[g*DW +: DW] == alm[g]);
  end

  assign match     = &fld_eq;
  assign alarm_hit = tick_sec && match && !match_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        match_q <= 1'b0;
    else if (tick_sec) match_q <= match;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ictl <= '0;
    else if (int_wr) ictl <= reg_wdata[3:0];

  assign sts_set = {1'b0, alarm_hit, tick_day, tick_hour, tick_min, tick_sec};
  assign sts_clr = sts_wr ? reg_wdata[7:2] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= 6'b100000;
    else        sts <= (sts & ~sts_clr) | sts_set;

  assign per_sts = sts[5:2];
  assign irq = (sts[6] && ictl[3]) || (per_sts[ictl[1:0]] && ictl[2]);

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NFLD; i++)
      if (reg_addr == AW'(ALM_BASE + i)) reg_rdata = alm[i];
    if (reg_addr == STS_A) reg_rdata = {sts, 2'b00};
    if (reg_addr == INT_A) reg_rdata = {4'b0000, ictl};
  end

  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && match && !match_q) |=> sts[6]); // R4
  AST_NO_UNTICKED_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts[6] && !tick_sec) |=> !sts[6]); // R5
  AST_PWRUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && reg_wdata[7]) |=> !sts[7]); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_min && sts_wr && reg_wdata[3]) |=> sts[3]); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_we) |=> irq); // R9
  AST_INT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == INT_A) |-> (reg_rdata[7:4] == 4'b0000)); // R2
endmodule

// File: tb/rtc_event_unit_bench.sv
`timescale 1ns/1ps
module rtc_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [47:0] now_time = '0;
  logic        tick_sec = 0, tick_min = 0, tick_hour = 0, tick_day = 0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_alm [6];
  int m_int, m_sts;
  bit m_prev;

  always #2.5 clk = ~clk;

  rtc_event_unit u_rtc_event_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .now_time(now_time),
    .tick_sec(tick_sec), .tick_min(tick_min), .tick_hour(tick_hour),
    .tick_day(tick_day), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (m_alm[i]) m_alm[i] = 0;
    m_int = 0; m_sts = 8'h80; m_prev = 0;
  endtask

  function automatic int exp_rd(input int a);
    if (a >= 7 && a <= 12) return m_alm[a-7];
    if (a == 14) return m_sts;
    if (a == 15) return m_int;
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a >= 7 && a <= 12) return "R1";
    if (a == 14) return "R7";
    if (a == 15) return "R2";
    return "R10";
  endfunction

  function automatic int exp_irq();
    int pb;
    pb = 2 + (m_int & 3);
    return ((m_sts[6] && m_int[3]) || (m_sts[pb] && m_int[2])) ? 1 : 0;
  endfunction

  task automatic model_step();
    bit eq; int ev, clr;
    eq = 1;
    for (int i = 0; i < 6; i++) if (now_time[i*8 +: 8] != m_alm[i]) eq = 0;
    ev = 0;
    if (tick_sec)  ev |= 8'h04;
    if (tick_min)  ev |= 8'h08;
    if (tick_hour) ev |= 8'h10;
    if (tick_day)  ev |= 8'h20;
    if (tick_sec && eq && !m_prev) ev |= 8'h40;
    if (tick_sec) m_prev = eq;
    clr = (reg_we && reg_addr == 14) ? reg_wdata : 0;
    m_sts = ((m_sts & ~clr) | ev) & 8'hFC;
    if (reg_we && reg_addr >= 7 && reg_addr <= 12) m_alm[reg_addr-7] = reg_wdata;
    if (reg_we && reg_addr == 15) m_int = reg_wdata & 8'h0F;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R9 irq", irq, exp_irq());
    check({tag_of(reg_addr), " rdata"}, reg_rdata, exp_rd(reg_addr));
    reg_we = 0; tick_sec = 0; tick_min = 0; tick_hour = 0; tick_day = 0;
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
    cyc();
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    reg_we = 0; reg_addr = 5'(a);
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  localparam logic [47:0] T0 = 48'h25_06_15_12_30_45;

  initial begin
    model_reset();
    #12;
    @(negedge clk);
    rst_n = 1;
    peek(14, 8'h80, "R6 power-up after reset");
    peek(15, 8'h00, "R2 int reg reset");
    peek(9, 8'h00, "R1 alarm reset");
    cyc();

    // R1 alarm registers
    for (int i = 0; i < 6; i++) wr(7 + i, T0[i*8 +: 8]);
    for (int i = 0; i < 6; i++) peek(7 + i, T0[i*8 +: 8], "R1 alarm readback");

    // R2 upper bits ignored
    wr(15, 8'hF0);
    peek(15, 8'h00, "R2 upper bits");

    // R3 strobes with enables off
    tick_min = 1; tick_day = 1; cyc();
    peek(14, 8'hA8, "R3 min/day status");
    check("R3 irq off", irq, 0);

    // R7 clear power-up and min, keep day
    wr(14, 8'h88);
    peek(14, 8'h20, "R7 w1c selective");
    wr(14, 8'h20);
    peek(14, 8'h00, "R7 status clear");

    // R4 alarm fires
    now_time = T0; tick_sec = 1; cyc();
    peek(14, 8'h44, "R4 alarm status");
    // R5 no re-fire
    wr(14, 8'h44);
    now_time = T0; tick_sec = 1; cyc();
    peek(14, 8'h04, "R5 no refire");
    // leave match then return: fires again
    now_time = T0 + 1; tick_sec = 1; cyc();
    now_time = T0; tick_sec = 1; cyc();
    peek(14, 8'h44, "R4 refire after mismatch");

    // R9 alarm irq
    wr(15, 8'h08);
    check("R9 alarm irq", irq, 1);
    repeat (3) cyc();
    check("R9 irq held", irq, 1);
    wr(14, 8'h40);
    check("R9 irq cleared", irq, 0);

    // R9 periodic select: hour
    wr(15, 8'h06);
    check("R9 no hour event", irq, 0);
    tick_sec = 1; now_time = T0 + 2; cyc();
    check("R9 sec not selected", irq, 0);
    tick_hour = 1; cyc();
    check("R9 hour irq", irq, 1);
    wr(14, 8'h10);
    check("R9 hour cleared", irq, 0);

    // R8 event vs clear in same cycle
    tick_min = 1; reg_we = 1; reg_addr = 14; reg_wdata = 8'h08; cyc();
    peek(14, 8'h0C, "R8 min set wins");
    wr(14, 8'hFF);
    wr(8, 8'h00);
    now_time = {T0[47:16], 8'h00, T0[7:0]}; tick_sec = 1;
    reg_we = 1; reg_addr = 14; reg_wdata = 8'h40; cyc();
    peek(14, 8'h44, "R8 alarm set wins");

    // R10 unmapped
    wr(31, 8'hFF); wr(13, 8'hFF); wr(6, 8'h5A);
    peek(31, 0, "R10 unmapped read");
    peek(13, 0, "R10 unmapped read gap");
    peek(7, T0[7:0], "R10 alarm untouched");
    peek(15, 8'h06, "R10 int untouched");

    // R6 reset mid-run
    @(negedge clk);
    rst_n = 0; model_reset();
    #1;
    peek(14, 8'h80, "R6 reset sets power-up");
    @(negedge clk);
    rst_n = 1;
    repeat (4) cyc();
    peek(14, 8'h80, "R6 power-up sticky");

    // randomized phase against model
    for (int i = 0; i < 6; i++) wr(7 + i, T0[i*8 +: 8]);
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      now_time = (r < 40) ? T0 : T0 + 48'($urandom_range(0, 2));
      tick_sec  = ($urandom_range(0, 2) == 0);
      tick_min  = ($urandom_range(0, 7) == 0);
      tick_hour = ($urandom_range(0, 15) == 0);
      tick_day  = ($urandom_range(0, 31) == 0);
      reg_we = ($urandom_range(0, 4) == 0);
      case ($urandom_range(0, 5))
        0, 1: reg_addr = 14;
        2: reg_addr = 15;
        3: reg_addr = 5'($urandom_range(7, 12));
        4: reg_addr = 31;
        default: reg_addr = 5'($urandom_range(0, 31));
      endcase
      reg_wdata = 8'($urandom);
      if (reg_we && reg_addr >= 7 && reg_addr <= 12 && r < 70)
        reg_wdata = T0[(reg_addr-7)*8 +: 8];
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R9 irq rand", irq, exp_irq());
      check({tag_of(reg_addr), " rdata rand"}, reg_rdata, exp_rd(reg_addr));
    end
    reg_we = 0; tick_sec = 0; tick_min = 0; tick_hour = 0; tick_day = 0;
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule